// File: doc/BRIEF.md
# Serial Character Receiver with Per-Entry Status

This block turns an asynchronous serial input into received characters. The line is first passed through a two-flop synchronizer. A 16x oversampling strobe, supplied from outside, then paces a small state machine. It finds a start bit and samples every later bit once, at its centre. It then rebuilds a character of 5 to 8 data bits, followed by an optional parity bit and one or two stop bits. The data length, the parity mode and the stop count are run-time inputs.

Each finished character goes into a 16-entry receive queue as a 12-bit word. The status of that character travels in the same word: framing error, parity error, break and overrun. No separate global register holds it. A line held low for a whole frame is reported as one break entry. The receiver then waits for the line to go high again. A character that arrives while the queue is full is discarded, and the next stored word carries the overrun flag. Two enables gate the hunt for a new start bit. When they are dropped, a character already in progress still finishes and is stored.

Top module: `urx_top`

## Requirements
- R1: After reset the queue is empty: `q_empty` is 1 and `q_full` is 0.
- R2: A falling edge starts a candidate start bit. If the line is high again at the sample taken 8 strobes later, the candidate is dropped, nothing is stored and the receiver goes back to hunting.
- R3: Data bits arrive least significant bit first. `cfg_len` selects the count: 0=5, 1=6, 2=7, 3=8 bits. The data sits in word bits [7:0], and the bits above the selected length read 0.
- R4: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_odd`=0 requires an even number of ones across the data and parity bits, and 1 requires an odd number. A mismatch sets word bit 9. With parity off, bit 9 is 0.
- R5: `cfg_stop2`=1 adds a second stop bit. A stop bit sampled low sets word bit 8.
- R6: If the line is low from the start bit through the last stop bit, exactly one word is stored: data 0, bits 10 and 8 set, bit 9 clear. Nothing more is received until the line has been high again and a new start bit arrives.
- R7: A character that completes while the queue holds 16 words is discarded. The next word that is stored has bit 11 set, and the words after it have bit 11 clear.
- R8: While `unit_en` or `rx_en` is 0, no new character is started. Clearing either one during a character still lets that character be stored.
- R9: The queue holds 16 words and returns them in arrival order. `q_rdata` shows the oldest word. `q_pop` removes it when the queue is not empty, and `q_full` is 1 when 16 words are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| unit_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| q_pop | input | 1 | Remove the oldest word |
| q_rdata | output | 12 | Oldest word: {overrun, break, parity err, framing err, data[7:0]} |
| q_empty | output | 1 | Queue holds no word |
| q_full | output | 1 | Queue holds 16 words |

## Verification
Two functions can act on the same word. The first is a break. The second is the overrun left behind by a character that was lost earlier. The bench fills the queue with 16 characters and sends one more, which is lost. It pops one word and then holds the line low for a full frame. The break word is judged when it reaches the head of the queue: it must carry the overrun, break and framing bits together with zero data. The character after it must carry no overrun.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
  } rx_state_e;

  // data length from the configuration code
  function automatic logic [3:0] urx_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // 1 when the received parity bit disagrees with the selected mode
  function automatic logic urx_par_err(input logic [7:0] d, input logic pbit,
                                       input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end
  assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        line,
  input  logic        en,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        cfg_stop2,
  output logic        done,
  output logic [10:0] done_word
);
  rx_state_e   state;
  logic [3:0]  tcnt;
  logic [2:0]  bitcnt;
  logic        stop_idx;
  logic [7:0]  sh;
  logic        pbit, ferr, all_low, prev_line;

  // named internal events
  logic mid_pt, start_fail, last_data, last_stop, brk_now;
  assign mid_pt     = tick16 && ((state == S_START) ? (tcnt == 4'd7) : (tcnt == 4'd15));
  assign start_fail = (state == S_START) && mid_pt && line;
  assign last_data  = ({1'b0, bitcnt} == urx_len(cfg_len) - 4'd1);
  assign last_stop  = !cfg_stop2 || stop_idx;
  assign brk_now    = all_low && !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tcnt <= '0; bitcnt <= '0; stop_idx <= 1'b0;
      sh <= '0; pbit <= 1'b0; ferr <= 1'b0; all_low <= 1'b0;
      prev_line <= 1'b1; done <= 1'b0; done_word <= '0;
    end else begin
      prev_line <= line;
      done      <= 1'b0;
      if (tick16 && state != S_IDLE && state != S_WAITHI) tcnt <= tcnt + 4'd1;
      unique case (state)
        S_IDLE: if (en && prev_line && !line) begin
          state <= S_START; tcnt <= '0;
        end
        S_START: if (mid_pt) begin
          if (line) state <= S_IDLE;
          else begin
            state <= S_DATA; tcnt <= '0; bitcnt <= '0; sh <= '0;
            all_low <= 1'b1; ferr <= 1'b0; pbit <= 1'b0;
          end
        end
        S_DATA: if (mid_pt) begin
          sh[bitcnt] <= line;
          all_low    <= all_low & !line;
          if (last_data) begin
            state <= cfg_par_en ? S_PAR : S_STOP; stop_idx <= 1'b0;
          end else bitcnt <= bitcnt + 3'd1;
        end
        S_PAR: if (mid_pt) begin
          pbit <= line; all_low <= all_low & !line; state <= S_STOP;
        end
        S_STOP: if (mid_pt) begin
          if (!last_stop) begin
            stop_idx <= 1'b1; all_low <= all_low & !line;
            ferr <= ferr | !line;
          end else begin
            done <= 1'b1;
            if (brk_now) begin
              done_word <= {1'b1, 1'b0, 1'b1, 8'h00};
              state     <= S_WAITHI;
            end else begin
              done_word <= {1'b0,
                            cfg_par_en && urx_par_err(sh, pbit, cfg_par_odd),
                            ferr | !line, sh};
              state     <= S_IDLE;
            end
          end
        end
        S_WAITHI: if (line) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fail |=> (state == S_IDLE && !done));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !en) |=> (state == S_IDLE));
  // R6
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && mid_pt && last_stop && brk_now) |-> (sh == 8'h00));
  // R6
  waithi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAITHI) |=> (!done));
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) if (do_push) mem[wptr] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R9
  fifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R9
  fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/urx_top.sv
module urx_top
  import urx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_line,
  input  logic        unit_en,
  input  logic        rx_en,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        cfg_stop2,
  input  logic        q_pop,
  output logic [11:0] q_rdata,
  output logic        q_empty,
  output logic        q_full
);
  logic        line_s, done, lost, push;
  logic [10:0] word;

  urx_sync #(.STAGES(2)) u_sync (.clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s));

  urx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line(line_s),
    .en(unit_en && rx_en), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .done(done), .done_word(word));

  assign push = done && !q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lost <= 1'b0;
    else if (done && q_full)  lost <= 1'b1;
    else if (push)            lost <= 1'b0;
  end

  urx_fifo #(.DEPTH(DEPTH), .WIDTH(12)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata({lost, word}),
    .pop(q_pop), .rdata(q_rdata), .empty(q_empty), .full(q_full));

  // R7
  lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && q_full) |=> lost);
  // R7
  lost_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !(done && q_full)) |=> !lost);
endmodule

// File: tb/sim_urx_top.sv
module sim_urx_top;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx_line = 1'b1;
  logic unit_en = 1'b1, rx_en = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic cfg_stop2 = 1'b0, q_pop = 1'b0;
  logic [1:0]  cfg_len = 2'd3;
  logic [11:0] q_rdata;
  logic        q_empty, q_full;
  int total = 0, fails = 0;
  logic [1:0] tdiv = '0;

  always #5 clk = ~clk;
  always_ff @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  urx_top u0 (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .unit_en(unit_en), .rx_en(rx_en), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .q_pop(q_pop),
    .q_rdata(q_rdata), .q_empty(q_empty), .q_full(q_full));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int bits);
    @(negedge clk) rx_line = b;
    repeat (64*bits - 1) @(negedge clk);
  endtask

  // one frame with the current configuration; bad_par flips parity, bad_stop lowers the last stop
  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int n = 5 + int'(cfg_len);
    logic p = 1'b0;
    hold(1'b0, 1);
    for (int i = 0; i < n; i++) begin
      hold(d[i], 1);
      p ^= d[i];
    end
    if (cfg_par_en) hold(p ^ cfg_par_odd ^ bad_par, 1);
    if (cfg_stop2) hold(1'b1, 1);
    hold(!bad_stop, 1);
    hold(1'b1, 1);
  endtask

  task automatic pop_expect(input logic [11:0] exp, input string what);
    @(negedge clk);
    check(!q_empty, {what, " word present"}, int'(q_empty), 0);
    check(q_rdata == exp, what, int'(q_rdata), int'(exp));
    q_pop = 1'b1;
    @(negedge clk) q_pop = 1'b0;
  endtask

  task automatic t_reset;
    check(q_empty && !q_full, "R1 reset empty/full", {q_empty, q_full}, 2'b10);
  endtask

  task automatic t_formats;
    cfg_len = 2'd3; send(8'hA5, 0, 0);
    pop_expect(12'h0A5, "R3 8 data bits");
    cfg_len = 2'd0; send(8'hFB, 0, 0);
    pop_expect(12'h01B, "R3 5 data bits upper zero");
    cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; send(8'h55, 0, 0);
    pop_expect(12'h055, "R4 even parity good");
    cfg_par_odd = 1'b1; send(8'h33, 1, 0);
    pop_expect(12'h233, "R4 odd parity bad");
    cfg_par_en = 1'b0; cfg_len = 2'd1; cfg_stop2 = 1'b1; send(8'h2C, 0, 0);
    pop_expect(12'h02C, "R5 two stops good");
    send(8'h2C, 0, 1);
    pop_expect(12'h12C, "R5 second stop low");
    cfg_stop2 = 1'b0; cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h81, 1, 1);
    pop_expect(12'h381, "R4 R5 parity and framing");
    cfg_par_en = 1'b0;
  endtask

  task automatic t_glitch;
    @(negedge clk) rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (700) @(negedge clk);
    check(q_empty, "R2 short low pulse ignored", int'(q_empty), 1);
  endtask

  task automatic t_break;
    hold(1'b0, 14);
    hold(1'b1, 2);
    pop_expect(12'h500, "R6 break word");
    @(negedge clk);
    check(q_empty, "R6 single break word", int'(q_empty), 1);
    send(8'h3C, 0, 0);
    pop_expect(12'h03C, "R6 receive after break");
  endtask

  task automatic t_enable;
    unit_en = 1'b0; send(8'h11, 0, 0);
    check(q_empty, "R8 unit disabled", int'(q_empty), 1);
    unit_en = 1'b1;
    fork
      send(8'h96, 0, 0);
      begin repeat (200) @(negedge clk); rx_en = 1'b0; end
    join
    send(8'h22, 0, 0);
    pop_expect(12'h096, "R8 char finishes after disable");
    @(negedge clk);
    check(q_empty, "R8 no start while disabled", int'(q_empty), 1);
    rx_en = 1'b1;
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 16; i++) send(8'(i + 8'h40), 0, 0);
    @(negedge clk);
    check(q_full, "R9 full at 16", int'(q_full), 1);
    send(8'hEE, 0, 0);
    pop_expect(12'h040, "R9 oldest first");
    hold(1'b0, 12);
    hold(1'b1, 2);
    for (int i = 1; i < 16; i++) pop_expect(12'(i + 8'h40), "R9 order after overrun");
    pop_expect(12'hD00, "R7 R6 overrun on break word");
    send(8'h5A, 0, 0);
    pop_expect(12'h05A, "R7 overrun cleared");
    @(negedge clk);
    check(q_empty, "R9 drained", int'(q_empty), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_formats;
    t_glitch;
    t_break;
    t_enable;
    t_overrun;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule